// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block keeps the per-warp lane mask of a SIMT core. Every lane of the warp steps through every instruction, but only lanes whose bit is set in the active mask may write their results. When a branch splits the active lanes, the block saves the current mask and the two follow-on addresses on an internal stack. It then narrows the mask to the lanes that take the branch. An else marker switches the mask to the lanes that fell through and redirects fetch to the fall-through address. A join marker acts as the barrier where both paths rejoin: the saved mask comes back and fetch resumes at the join address.

A branch whose active lanes all agree does not touch the stack and only redirects fetch. The front end presents the markers, one predicate bit per lane and three addresses for each branch. All results are registered and appear after the clock edge that samples the marker. A branch that would split the lanes while the stack is full, and a join on an empty stack, each set a sticky error flag and change nothing else.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the active mask is all ones, the stack is empty, the redirect strobe is low and both error flags are clear.
- R2: A branch where every active lane has its predicate set leaves the mask unchanged, pushes nothing, and redirects to the target address.
- R3: A branch where no active lane has its predicate set leaves the mask unchanged, pushes nothing, and redirects to the fall-through address. Predicate bits of inactive lanes have no effect.
- R4: A branch with both outcomes among the active lanes, and a stack that is not full, pushes one entry. The new mask is the active mask AND the predicate, and fetch is redirected to the target address. The mask never becomes all zeros.
- R5: An else marker sets the mask to the mask saved on the top entry AND NOT its predicate, and redirects to that entry's fall-through address. An else marker on an empty stack changes nothing and raises no redirect.
- R6: A join marker pops the top entry, restores the mask saved in it, and redirects to its join address.
- R7: Entries nest up to DEPTH deep and are restored in last-in, first-out order.
- R8: A splitting branch with DEPTH entries held sets err_overflow. The flag stays set until reset, and the mask, the stack and the redirect strobe are left as they were.
- R9: A join on an empty stack sets err_underflow. The flag stays set until reset, and the mask and redirect strobe are left as they were.
- R10: When several markers arrive in one cycle, join wins over else and else wins over branch. The losing markers are ignored.
- R11: Each result appears after the first rising edge that samples the marker. The redirect strobe is high for exactly one cycle per redirect and low in any cycle that follows one with no marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_branch | input | 1 | Branch marker |
| op_else | input | 1 | Else marker (switch to the fall-through path) |
| op_join | input | 1 | Join marker (reconvergence barrier) |
| lane_pred | input | LANES | Per-lane branch predicate |
| target_pc | input | PC_W | Branch target address |
| fallthru_pc | input | PC_W | Address after the branch |
| join_pc | input | PC_W | Address where the paths rejoin |
| active_mask | output | LANES | Lanes allowed to commit results |
| redirect | output | 1 | One-cycle strobe: fetch from redirect_pc |
| redirect_pc | output | PC_W | Next fetch address when redirect is high |
| err_overflow | output | 1 | Sticky: a push was refused because the stack was full |
| err_underflow | output | 1 | Sticky: a join arrived with an empty stack |

## Verification
On every cycle the bound checker verifies several rules: the mask is never empty, uniform branches and idle cycles leave the mask alone, a split narrows the mask to the active lanes that take the branch, and refused pushes or pops set their flags without touching the mask. Values that come back from the stack can only be shown by the bench scenarios. These include the mask and addresses restored by else and join, last-in, first-out order across four nested levels, the marker priority, and flags that clear only at reset.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_BRANCH = 2'd1,
      ACT_ELSE   = 2'd2,
      ACT_JOIN   = 2'd3
   } div_act_e;

   function automatic div_act_e pick_action(input logic br, input logic el, input logic jn);
      if (jn)      return ACT_JOIN;
      else if (el) return ACT_ELSE;
      else if (br) return ACT_BRANCH;
      else         return ACT_NONE;
   endfunction

endpackage

// File: rtl/simt_div_decode.sv
module simt_div_decode
   import simt_div_pkg::*;
(
   input  logic     br_i,
   input  logic     else_i,
   input  logic     join_i,
   output div_act_e act_o
);
   always_comb act_o = pick_action(br_i, else_i, join_i);
endmodule

// File: rtl/simt_div_eval.sv
module simt_div_eval #(
   parameter int LANES = 32
) (
   input  logic [LANES-1:0] active_i,
   input  logic [LANES-1:0] pred_i,
   output logic [LANES-1:0] take_mask_o,
   output logic [LANES-1:0] fall_mask_o,
   output logic             none_take_o,
   output logic             all_take_o,
   output logic             split_o
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign take_mask_o[l] = active_i[l] &  pred_i[l];
      assign fall_mask_o[l] = active_i[l] & ~pred_i[l];
   end

   assign none_take_o = ~|take_mask_o;
   assign all_take_o  = ~|fall_mask_o;
   assign split_o     = ~none_take_o & ~all_take_o;
endmodule

// File: rtl/simt_div_stack.sv
module simt_div_stack #(
   parameter int LANES = 32,
   parameter int DEPTH = 8,
   parameter int PC_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [LANES-1:0] save_mask_i,
   input  logic [LANES-1:0] alt_mask_i,
   input  logic [PC_W-1:0]  alt_pc_i,
   input  logic [PC_W-1:0]  rejoin_pc_i,
   output logic [LANES-1:0] top_save_mask_o,
   output logic [LANES-1:0] top_alt_mask_o,
   output logic [PC_W-1:0]  top_alt_pc_o,
   output logic [PC_W-1:0]  top_rejoin_pc_o,
   output logic             full_o,
   output logic             empty_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0] fill_q;
   logic [LANES-1:0] save_mask_q [DEPTH];
   logic [LANES-1:0] alt_mask_q  [DEPTH];
   logic [PC_W-1:0]  alt_pc_q    [DEPTH];
   logic [PC_W-1:0]  rejoin_pc_q [DEPTH];

   assign full_o  = (fill_q == CNT_W'(DEPTH));
   assign empty_o = (fill_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         fill_q <= '0;
      else if (push_i && !full_o)
         fill_q <= fill_q + 1'b1;
      else if (pop_i && !empty_o)
         fill_q <= fill_q - 1'b1;
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            save_mask_q[e] <= '0;
            alt_mask_q[e]  <= '0;
            alt_pc_q[e]    <= '0;
            rejoin_pc_q[e] <= '0;
         end else if (push_i && !full_o && fill_q == CNT_W'(e)) begin
            save_mask_q[e] <= save_mask_i;
            alt_mask_q[e]  <= alt_mask_i;
            alt_pc_q[e]    <= alt_pc_i;
            rejoin_pc_q[e] <= rejoin_pc_i;
         end
      end
   end

   always_comb begin
      top_save_mask_o = '0;
      top_alt_mask_o  = '0;
      top_alt_pc_o    = '0;
      top_rejoin_pc_o = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (fill_q == CNT_W'(e + 1)) begin
            top_save_mask_o = save_mask_q[e];
            top_alt_mask_o  = alt_mask_q[e];
            top_alt_pc_o    = alt_pc_q[e];
            top_rejoin_pc_o = rejoin_pc_q[e];
         end
      end
   end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
   import simt_div_pkg::*;
#(
   parameter int LANES = 32,
   parameter int DEPTH = 8,
   parameter int PC_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_branch,
   input  logic             op_else,
   input  logic             op_join,
   input  logic [LANES-1:0] lane_pred,
   input  logic [PC_W-1:0]  target_pc,
   input  logic [PC_W-1:0]  fallthru_pc,
   input  logic [PC_W-1:0]  join_pc,
   output logic [LANES-1:0] active_mask,
   output logic             redirect,
   output logic [PC_W-1:0]  redirect_pc,
   output logic             err_overflow,
   output logic             err_underflow
);
   if (LANES < 2) begin : g_bad_lanes
      $error("simt_reconv_stack: LANES must be at least 2");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("simt_reconv_stack: DEPTH must be at least 1");
   end
   if (PC_W < 2) begin : g_bad_pcw
      $error("simt_reconv_stack: PC_W must be at least 2");
   end

   div_act_e         act;
   logic [LANES-1:0] take_mask, fall_mask;
   logic             none_take, all_take, split;
   logic             do_push, do_pop;
   logic [LANES-1:0] top_save, top_alt;
   logic [PC_W-1:0]  top_alt_pc, top_join_pc;
   logic             stk_full, stk_empty;

   simt_div_decode u_dec (
      .br_i   (op_branch),
      .else_i (op_else),
      .join_i (op_join),
      .act_o  (act)
   );

   simt_div_eval #(.LANES(LANES)) u_eval (
      .active_i    (active_mask),
      .pred_i      (lane_pred),
      .take_mask_o (take_mask),
      .fall_mask_o (fall_mask),
      .none_take_o (none_take),
      .all_take_o  (all_take),
      .split_o     (split)
   );

   assign do_push = (act == ACT_BRANCH) && split && !stk_full;
   assign do_pop  = (act == ACT_JOIN) && !stk_empty;

   simt_div_stack #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) u_stk (
      .clk             (clk),
      .rst_n           (rst_n),
      .push_i          (do_push),
      .pop_i           (do_pop),
      .save_mask_i     (active_mask),
      .alt_mask_i      (fall_mask),
      .alt_pc_i        (fallthru_pc),
      .rejoin_pc_i     (join_pc),
      .top_save_mask_o (top_save),
      .top_alt_mask_o  (top_alt),
      .top_alt_pc_o    (top_alt_pc),
      .top_rejoin_pc_o (top_join_pc),
      .full_o          (stk_full),
      .empty_o         (stk_empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_mask   <= '1;
         redirect      <= 1'b0;
         redirect_pc   <= '0;
         err_overflow  <= 1'b0;
         err_underflow <= 1'b0;
      end else begin
         redirect <= 1'b0;
         unique case (act)
            ACT_JOIN: begin
               if (stk_empty) begin
                  err_underflow <= 1'b1;
               end else begin
                  active_mask <= top_save;
                  redirect    <= 1'b1;
                  redirect_pc <= top_join_pc;
               end
            end
            ACT_ELSE: begin
               if (!stk_empty) begin
                  active_mask <= top_alt;
                  redirect    <= 1'b1;
                  redirect_pc <= top_alt_pc;
               end
            end
            ACT_BRANCH: begin
               if (none_take) begin
                  redirect    <= 1'b1;
                  redirect_pc <= fallthru_pc;
               end else if (all_take) begin
                  redirect    <= 1'b1;
                  redirect_pc <= target_pc;
               end else if (stk_full) begin
                  err_overflow <= 1'b1;
               end else begin
                  active_mask <= take_mask;
                  redirect    <= 1'b1;
                  redirect_pc <= target_pc;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
   parameter int LANES = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_branch,
   input logic             op_else,
   input logic             op_join,
   input logic [LANES-1:0] lane_pred,
   input logic [LANES-1:0] active_mask,
   input logic             redirect,
   input logic             err_overflow,
   input logic             err_underflow,
   input logic             stk_full,
   input logic             stk_empty
);
   logic br_only, splits, uniform, idle;
   assign br_only = op_branch && !op_else && !op_join;
   assign splits  = ((active_mask & lane_pred) != '0) && ((active_mask & ~lane_pred) != '0);
   assign uniform = !splits;
   assign idle    = !op_branch && !op_else && !op_join;

   assert_mask_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      active_mask != '0);

   assert_uniform_keeps_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      br_only && uniform |=> $stable(active_mask) && redirect);

   assert_split_narrows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      br_only && splits && !stk_full |=> redirect && active_mask == $past(active_mask & lane_pred));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      br_only && splits && stk_full |=> err_overflow && !redirect && $stable(active_mask));

   assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow |=> err_overflow);

   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      op_join && stk_empty |=> err_underflow && !redirect && $stable(active_mask));

   assert_underflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_underflow |=> err_underflow);

   assert_else_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      op_else && !op_join && stk_empty |=> !redirect && $stable(active_mask));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> !redirect && $stable(active_mask));
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(.LANES(LANES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .op_branch     (op_branch),
   .op_else       (op_else),
   .op_join       (op_join),
   .lane_pred     (lane_pred),
   .active_mask   (active_mask),
   .redirect      (redirect),
   .err_overflow  (err_overflow),
   .err_underflow (err_underflow),
   .stk_full      (stk_full),
   .stk_empty     (stk_empty)
);

// File: tb/simt_reconv_stack_test.sv
module simt_reconv_stack_test;
   localparam int LANES = 8;
   localparam int DEPTH = 4;
   localparam int PC_W  = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             op_branch = 1'b0, op_else = 1'b0, op_join = 1'b0;
   logic [LANES-1:0] lane_pred = '0;
   logic [PC_W-1:0]  target_pc = '0, fallthru_pc = '0, join_pc = '0;
   logic [LANES-1:0] active_mask;
   logic             redirect;
   logic [PC_W-1:0]  redirect_pc;
   logic             err_overflow, err_underflow;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   simt_reconv_stack #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) uut (
      .clk(clk), .rst_n(rst_n),
      .op_branch(op_branch), .op_else(op_else), .op_join(op_join),
      .lane_pred(lane_pred), .target_pc(target_pc), .fallthru_pc(fallthru_pc), .join_pc(join_pc),
      .active_mask(active_mask), .redirect(redirect), .redirect_pc(redirect_pc),
      .err_overflow(err_overflow), .err_underflow(err_underflow)
   );

   // req[4] ops{join,else,branch}[3] pred[8] tgt[16] fall[16] join[16] mask[8] redir[1] pc[16]
   typedef struct packed {
      logic [3:0]  req;
      logic [2:0]  ops;
      logic [7:0]  pred;
      logic [15:0] tgt;
      logic [15:0] fall;
      logic [15:0] jn;
      logic [7:0]  mask;
      logic        redir;
      logic [15:0] pc;
   } vec_t;

   localparam int NV = 14;
   localparam logic [87:0] VEC [NV] = '{
      {4'd2,  3'b001, 8'hFF, 16'h0100, 16'h0004, 16'h0008, 8'hFF, 1'b1, 16'h0100}, // R2 uniform taken
      {4'd3,  3'b001, 8'h00, 16'h0200, 16'h0010, 16'h0018, 8'hFF, 1'b1, 16'h0010}, // R3 uniform not taken
      {4'd4,  3'b001, 8'h0F, 16'h0300, 16'h0020, 16'h0040, 8'h0F, 1'b1, 16'h0300}, // R4 split
      {4'd11, 3'b000, 8'hFF, 16'h0000, 16'h0000, 16'h0000, 8'h0F, 1'b0, 16'h0000}, // R11 idle
      {4'd4,  3'b001, 8'hF3, 16'h0500, 16'h0050, 16'h0060, 8'h03, 1'b1, 16'h0500}, // R4 nested split
      {4'd3,  3'b001, 8'hFC, 16'h0700, 16'h0070, 16'h0078, 8'h03, 1'b1, 16'h0070}, // R3 inactive preds ignored
      {4'd5,  3'b010, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h0C, 1'b1, 16'h0050}, // R5 else inner
      {4'd6,  3'b100, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h0F, 1'b1, 16'h0060}, // R6 join inner
      {4'd5,  3'b010, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'hF0, 1'b1, 16'h0020}, // R5 else outer
      {4'd6,  3'b100, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'hFF, 1'b1, 16'h0040}, // R6 join outer
      {4'd5,  3'b010, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'hFF, 1'b0, 16'h0000}, // R5 else on empty
      {4'd4,  3'b001, 8'h55, 16'h0800, 16'h0080, 16'h0090, 8'h55, 1'b1, 16'h0800}, // R4 split again
      {4'd10, 3'b011, 8'hAA, 16'h0900, 16'h0099, 16'h009A, 8'hAA, 1'b1, 16'h0080}, // R10 else beats branch
      {4'd10, 3'b111, 8'h0F, 16'h0A00, 16'h00A1, 16'h00A2, 8'hFF, 1'b1, 16'h0090}  // R10 join beats all
   };

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive just after a negedge; marker seen on one rising edge; return at next negedge
   task automatic apply(input logic [2:0] ops, input logic [7:0] pred,
                        input logic [15:0] tgt, input logic [15:0] fall, input logic [15:0] jn);
      {op_join, op_else, op_branch} = ops;
      lane_pred = pred; target_pc = tgt; fallthru_pc = fall; join_pc = jn;
      @(posedge clk);
      #1;
      {op_join, op_else, op_branch} = 3'b000;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin : main
      vec_t v;
      string rq;
      do_reset();
      check("R1", "mask", 32'(active_mask), 32'hFF);
      check("R1", "redirect", 32'(redirect), 32'h0);
      check("R1", "ovf", 32'(err_overflow), 32'h0);
      check("R1", "unf", 32'(err_underflow), 32'h0);

      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         rq = $sformatf("R%0d(vec %0d)", v.req, i);
         apply(v.ops, v.pred, v.tgt, v.fall, v.jn);
         check(rq, "mask", 32'(active_mask), 32'(v.mask));
         check(rq, "redirect", 32'(redirect), 32'(v.redir));
         if (v.redir) check(rq, "pc", 32'(redirect_pc), 32'(v.pc));
      end
      @(negedge clk);
      check("R11", "strobe drops", 32'(redirect), 32'h0);

      // R7 / R8: fill DEPTH levels, then a refused split
      do_reset();
      for (int k = 0; k < DEPTH; k++) begin
         apply(3'b001, 8'h7F >> k, 16'h2000 + 16'(k), 16'h3000 + 16'(k), 16'h1000 + 16'(k));
         check("R7", "push mask", 32'(active_mask), 32'(8'h7F >> k));
      end
      apply(3'b001, 8'h07, 16'h2FFF, 16'h3FFF, 16'h1FFF);
      check("R8", "ovf flag", 32'(err_overflow), 32'h1);
      check("R8", "mask held", 32'(active_mask), 32'h0F);
      check("R8", "no redirect", 32'(redirect), 32'h0);
      apply(3'b000, 8'h00, 16'h0, 16'h0, 16'h0);
      check("R8", "ovf sticky", 32'(err_overflow), 32'h1);

      for (int k = DEPTH - 1; k >= 0; k--) begin
         apply(3'b100, 8'h00, 16'h0, 16'h0, 16'h0);
         check("R7", "pop mask", 32'(active_mask), (k == 0) ? 32'hFF : 32'(8'h7F >> (k - 1)));
         check("R7", "pop pc", 32'(redirect_pc), 32'h1000 + 32'(k));
      end

      // R9: join with nothing held
      apply(3'b100, 8'h00, 16'h0, 16'h0, 16'h0);
      check("R9", "unf flag", 32'(err_underflow), 32'h1);
      check("R9", "mask held", 32'(active_mask), 32'hFF);
      check("R9", "no redirect", 32'(redirect), 32'h0);
      apply(3'b000, 8'h00, 16'h0, 16'h0, 16'h0);
      check("R9", "unf sticky", 32'(err_underflow), 32'h1);

      do_reset();
      check("R1", "ovf cleared", 32'(err_overflow), 32'h0);
      check("R1", "unf cleared", 32'(err_underflow), 32'h0);
      check("R1", "mask after reset", 32'(active_mask), 32'hFF);
      apply(3'b100, 8'h00, 16'h0, 16'h0, 16'h0);
      check("R1", "stack empty after reset", 32'(err_underflow), 32'h1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule